// File: doc/BRIEF.md
# Bit-Control Parallel I/O Port

This block is a two-port, 8-bit parallel I/O controller that sits on a simple I/O-mapped CPU bus. Each port has an output latch, an output-enable vector and a registered sample of its pins. A port can be switched wholesale to output or input, or placed in bit-control mode. In that mode every pin is set to input or output on its own by a direction mask.

Decoding is deliberately loose. Only three upper address bits reach the block, so many I/O addresses alias onto the same four registers. A control write to a port is either a mode word or, directly after a bit-control mode word, that port's direction mask. Any other control byte is dropped. An inhibit input shuts the block off from the bus entirely. Strobes are synchronous: a write is taken at the clock edge where the request and write strobe are both high, and read data is combinational while a read is held.

Top module: `bitctl_pio`

## Requirements
- R1: After reset, the output latches of both ports are 0x00 and both output-enable vectors are 0x00, so every pin is an input. A data read returns the sampled pins.
- R2: The block acts only when `bus_iorq` is high and `addr_hi[2]` (address bit 7) is low. Writes that fail this test change no latch, mask or mode.
- R3: `addr_hi[0]` (address bit 5) selects port A (0) or port B (1). `addr_hi[1]` (address bit 6) selects data (0) or control (1). A data write loads that port's latch, and only that port's.
- R4: A control write whose bits 3:0 are 1111 is a mode word, with the mode in bits 7:6. Mode 0 makes all pins outputs (enable 0xFF). Modes 1 and 2 make all pins inputs (enable 0x00). Mode 3 selects bit control.
- R5: The control byte written to a port directly after its mode-3 word is that port's direction mask, whatever its value. A mask bit of 1 makes the pin an input, so the enable vector becomes the inverse of the mask. Until the mask arrives, all pins of that port are inputs.
- R6: A data write made between the mode-3 word and the mask still loads the latch, so pins that the mask turns into outputs drive that value.
- R7: While `inhibit` is high, the block ignores every access. Writes have no effect and reads return 0x00.
- R8: In bit-control mode, a data read returns the sampled pin level for input bits and the latch value for output bits. In mode 0 it returns the latch, and in modes 1 and 2 it returns the pins.
- R9: A control write that is neither a mode word nor an expected mask is ignored. It changes neither the mode nor the direction.
- R10: `rdata` is 0x00 unless a decoded data-register read is in progress. A read of a control address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_iorq | input | 1 | I/O request, active high |
| inhibit | input | 1 | Forces the I/O request inactive |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| addr_hi | input | 3 | Address bits 7,6,5 as [2],[1],[0] |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data |
| pa_in | input | DW | Port A pin levels |
| pa_out | output | DW | Port A output latch |
| pa_oe | output | DW | Port A output enables, 1 = drive |
| pb_in | input | DW | Port B pin levels |
| pb_out | output | DW | Port B output latch |
| pb_oe | output | DW | Port B output enables, 1 = drive |

## Verification
The bench builds the block with its default data width of 8. At that width the mode-word nibble, the mode field in bits 7:6, and the initialisation sequence that gives port B two outputs and port A none all fall at their real bit positions. That in turn puts three cases within reach: a mask byte that looks like a mode word, a latch written before its mask, and a mixed pin/latch read, each checked against hand-computed values. The A7-high alias, the idle request and the inhibit cases are driven with live write data to show that no state moves.

// File: rtl/bitctl_pio_pkg.sv
package bitctl_pio_pkg;

  typedef enum logic [1:0] {
    MODE_OUT    = 2'd0,
    MODE_IN     = 2'd1,
    MODE_BIDIR  = 2'd2,
    MODE_BITCTL = 2'd3
  } pio_mode_e;

  localparam logic [3:0] MODE_TAG = 4'hF;

  // Address codes as {A7, A6, A5}.
  localparam logic [2:0] SEL_DATA_A = 3'b000;
  localparam logic [2:0] SEL_DATA_B = 3'b001;
  localparam logic [2:0] SEL_CTRL_A = 3'b010;
  localparam logic [2:0] SEL_CTRL_B = 3'b011;

  function automatic logic is_mode_word(input logic [7:0] b);
    return b[3:0] == MODE_TAG;
  endfunction

  function automatic pio_mode_e mode_field(input logic [7:0] b);
    return pio_mode_e'(b[7:6]);
  endfunction

endpackage

// File: rtl/bitctl_pio_decode.sv
module bitctl_pio_decode #(
  parameter int NPORTS = 2
) (
  input  logic              bus_iorq,
  input  logic              inhibit,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [2:0]        addr_hi,
  output logic [NPORTS-1:0] wr_data,
  output logic [NPORTS-1:0] wr_ctrl,
  output logic [NPORTS-1:0] rd_data
);
  logic live;

  // Chip enable: request seen (not inhibited) and address bit 7 low.
  assign live = bus_iorq && !inhibit && !addr_hi[2];

  for (genvar p = 0; p < NPORTS; p++) begin : g_sel
    logic hit;
    assign hit        = live && (addr_hi[0] == p[0]);
    assign wr_data[p] = hit && bus_wr && !addr_hi[1];
    assign wr_ctrl[p] = hit && bus_wr &&  addr_hi[1];
    assign rd_data[p] = hit && bus_rd && !addr_hi[1];
  end
endmodule

// File: rtl/bitctl_pio_port.sv
module bitctl_pio_port
  import bitctl_pio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_data,
  input  logic          wr_ctrl,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] out_latch,
  output logic [DW-1:0] oe,
  output logic [DW-1:0] rd_value,
  output logic          mask_load,
  output logic          mode_load
);
  pio_mode_e     mode_q;
  logic [DW-1:0] dir_q;     // 1 = input (bit-control mode only)
  logic [DW-1:0] latch_q;
  logic [DW-1:0] pin_q;
  logic          pend_q;

  function automatic logic [DW-1:0] drive_mask(input pio_mode_e m,
                                               input logic [DW-1:0] dir);
    case (m)
      MODE_OUT:    return '1;
      MODE_BITCTL: return ~dir;
      default:     return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] read_mix(input logic [DW-1:0] pins,
                                             input logic [DW-1:0] lat,
                                             input logic [DW-1:0] drv);
    return (lat & drv) | (pins & ~drv);
  endfunction

  assign mask_load = wr_ctrl && pend_q;
  assign mode_load = wr_ctrl && !pend_q && is_mode_word(wdata[7:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_IN;
      dir_q   <= '1;
      latch_q <= '0;
      pin_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      pin_q <= pin_in;
      if (wr_data) latch_q <= wdata;
      if (mask_load) begin
        dir_q  <= wdata;
        pend_q <= 1'b0;
      end else if (mode_load) begin
        mode_q <= mode_field(wdata[7:0]);
        pend_q <= (mode_field(wdata[7:0]) == MODE_BITCTL);
        if (mode_field(wdata[7:0]) == MODE_BITCTL) dir_q <= '1;
      end
    end
  end

  assign out_latch = latch_q;
  assign oe        = drive_mask(mode_q, dir_q);
  assign rd_value  = read_mix(pin_q, latch_q, oe);
endmodule

// File: rtl/bitctl_pio.sv
module bitctl_pio
  import bitctl_pio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_iorq,
  input  logic          inhibit,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [2:0]    addr_hi,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe
);
  localparam int NPORTS = 2;

  logic [NPORTS-1:0] wr_data, wr_ctrl, rd_data;
  logic [NPORTS-1:0] mask_load, mode_load;
  logic [DW-1:0]     pin_v   [NPORTS];
  logic [DW-1:0]     latch_v [NPORTS];
  logic [DW-1:0]     oe_v    [NPORTS];
  logic [DW-1:0]     rd_v    [NPORTS];

  bitctl_pio_decode #(.NPORTS(NPORTS)) dec_i (
    .bus_iorq(bus_iorq), .inhibit(inhibit), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .addr_hi(addr_hi), .wr_data(wr_data), .wr_ctrl(wr_ctrl), .rd_data(rd_data)
  );

  assign pin_v[0] = pa_in;
  assign pin_v[1] = pb_in;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    bitctl_pio_port #(.DW(DW)) port_i (
      .clk(clk), .rst_n(rst_n),
      .wr_data(wr_data[p]), .wr_ctrl(wr_ctrl[p]), .wdata(wdata),
      .pin_in(pin_v[p]),
      .out_latch(latch_v[p]), .oe(oe_v[p]), .rd_value(rd_v[p]),
      .mask_load(mask_load[p]), .mode_load(mode_load[p])
    );
  end

  assign pa_out = latch_v[0];
  assign pa_oe  = oe_v[0];
  assign pb_out = latch_v[1];
  assign pb_oe  = oe_v[1];

  always_comb begin
    rdata = '0;
    for (int p = 0; p < NPORTS; p++)
      if (rd_data[p]) rdata = rd_v[p];
  end
endmodule

// File: rtl/bitctl_pio_checker.sv
module bitctl_pio_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_iorq,
  input logic          inhibit,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [2:0]    addr_hi,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic [DW-1:0] pa_out,
  input logic [DW-1:0] pa_oe,
  input logic [DW-1:0] pb_out,
  input logic [DW-1:0] pb_oe,
  input logic [1:0]    mask_load,
  input logic [1:0]    mode_load
);
  logic bus_live;
  assign bus_live = bus_iorq && !inhibit && !addr_hi[2];

  assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_live |=> ($stable(pa_out) && $stable(pa_oe) && $stable(pb_out) && $stable(pb_oe)));

  assert_data_a_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_live && bus_wr && addr_hi[1:0] == 2'b00) |=> (pa_out == $past(wdata) && $stable(pb_out)));

  assert_mode0_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_load[1] && wdata[7:6] == 2'b00) |=> pb_oe == '1);

  assert_mask_sets_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mask_load[0] |=> pa_oe == ~$past(wdata));

  assert_inhibit_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> rdata == '0);

  assert_ctrl_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && addr_hi[1]) |-> rdata == '0);

  assert_single_ctrl_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mask_load, mode_load}));
endmodule

bind bitctl_pio bitctl_pio_checker #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_iorq(bus_iorq), .inhibit(inhibit),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .addr_hi(addr_hi), .wdata(wdata),
  .rdata(rdata), .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
  .mask_load(mask_load), .mode_load(mode_load)
);

// File: tb/bitctl_pio_tb_top.sv
module bitctl_pio_tb_top;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_iorq = 1'b0, inhibit = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [2:0]    addr_hi = 3'b000;
  logic [DW-1:0] wdata = '0, pa_in = '0, pb_in = '0;
  logic [DW-1:0] rdata, pa_out, pa_oe, pb_out, pb_oe;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bitctl_pio #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_iorq(bus_iorq), .inhibit(inhibit),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .addr_hi(addr_hi), .wdata(wdata),
    .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe)
  );

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // Drive a write on the falling edge; it is taken at the next rising edge.
  task automatic bus_write(input logic [2:0] a, input logic [DW-1:0] d, input logic req = 1'b1);
    @(negedge clk);
    bus_iorq = req; bus_wr = 1'b1; addr_hi = a; wdata = d;
    @(negedge clk);
    bus_iorq = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_iorq = 1'b1; bus_rd = 1'b1; addr_hi = a;
    #1 d = rdata;
    @(negedge clk);
    bus_iorq = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic set_pins(input logic [DW-1:0] a, input logic [DW-1:0] b);
    @(negedge clk);
    pa_in = a; pb_in = b;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [DW-1:0] r;
    check("R1 pa_oe", pa_oe, 8'h00);
    check("R1 pb_oe", pb_oe, 8'h00);
    check("R1 pa_out", pa_out, 8'h00);
    check("R1 pb_out", pb_out, 8'h00);
    set_pins(8'h5A, 8'hA5);
    bus_read(3'b000, r); check("R1 read pins A", r, 8'h5A);
    bus_read(3'b001, r); check("R3 read pins B", r, 8'hA5);
  endtask

  task automatic t_mode_words;
    logic [DW-1:0] r;
    bus_write(3'b010, 8'h0F);
    check("R4 mode0 pa_oe", pa_oe, 8'hFF);
    check("R4 mode0 leaves pb_oe", pb_oe, 8'h00);
    bus_write(3'b000, 8'h3C);
    check("R3 data A latch", pa_out, 8'h3C);
    check("R3 data A leaves B", pb_out, 8'h00);
    bus_read(3'b000, r); check("R8 mode0 reads latch", r, 8'h3C);
    bus_read(3'b010, r); check("R10 ctrl read zero", r, 8'h00);
    bus_write(3'b011, 8'h4F);
    check("R4 mode1 pb_oe", pb_oe, 8'h00);
    bus_write(3'b011, 8'h8F);
    check("R4 mode2 pb_oe", pb_oe, 8'h00);
    bus_write(3'b001, 8'h77);
    check("R3 data B latch", pb_out, 8'h77);
    bus_read(3'b001, r); check("R8 mode2 reads pins", r, 8'hA5);
  endtask

  task automatic t_decode;
    logic [DW-1:0] r;
    bus_write(3'b100, 8'h99);
    check("R2 A7 high ignored", pa_out, 8'h3C);
    bus_write(3'b110, 8'h4F);
    check("R2 A7 high ctrl ignored", pa_oe, 8'hFF);
    bus_write(3'b000, 8'h66, 1'b0);
    check("R2 no iorq ignored", pa_out, 8'h3C);
    bus_read(3'b100, r); check("R10 undecoded read zero", r, 8'h00);
  endtask

  task automatic t_inhibit;
    logic [DW-1:0] r;
    inhibit = 1'b1;
    bus_write(3'b000, 8'h11);
    check("R7 inhibit data write", pa_out, 8'h3C);
    bus_write(3'b010, 8'h4F);
    check("R7 inhibit ctrl write", pa_oe, 8'hFF);
    bus_read(3'b000, r); check("R7 inhibit read zero", r, 8'h00);
    inhibit = 1'b0;
    bus_read(3'b000, r); check("R7 released read", r, 8'h3C);
  endtask

  task automatic t_bitctl_b;
    logic [DW-1:0] r;
    bus_write(3'b011, 8'hFF);
    check("R5 pending all inputs", pb_oe, 8'h00);
    bus_write(3'b001, 8'hFF);
    check("R6 latch before mask", pb_out, 8'hFF);
    bus_write(3'b011, 8'h3F);
    check("R5 mask 3F oe", pb_oe, 8'hC0);
    check("R6 outputs start high", pb_out & pb_oe, 8'hC0);
    set_pins(8'h5A, 8'h15);
    bus_read(3'b001, r); check("R8 mixed read B", r, 8'hD5);
  endtask

  task automatic t_bitctl_a;
    logic [DW-1:0] r;
    bus_write(3'b010, 8'hFF);
    bus_write(3'b010, 8'hFF);
    check("R5 mask FF all inputs", pa_oe, 8'h00);
    bus_write(3'b010, 8'h12);
    check("R9 stray ctrl no mask", pa_oe, 8'h00);
    bus_write(3'b010, 8'h55);
    check("R9 stray ctrl no mode", pa_oe, 8'h00);
    bus_read(3'b000, r); check("R8 all-input read A", r, 8'h5A);
    bus_write(3'b010, 8'hFF);
    bus_write(3'b010, 8'h0F);
    check("R5 mask that looks like mode word", pa_oe, 8'hF0);
    bus_read(3'b000, r); check("R8 mixed read A", r, 8'h3A);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_words();
    t_decode();
    t_inhibit();
    t_bitctl_b();
    t_bitctl_a();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule